// File: doc/BRIEF.md
# Three-Port Bridge Claim and Delayed Completion Unit

This block sits at the decision point of a bridge joining one upstream bus (port 0) to two downstream buses (ports 1 and 2). Each port has three address windows, one for each bus. Each cycle the block looks at any transaction on any port and checks its address against those windows. It then decides whether the bridge stays silent or claims the cycle by driving that port's device-select.

A claimed cycle that carries a memory write can be posted, so it finishes with normal termination at once. Every other claimed cycle goes down the delayed path. The block signals retry, records the request in the slot that belongs to the initiating port, and presents the request toward the target port. When the far side reports completion, the slot waits for the initiator to issue the identical cycle again. That repeated cycle then gets normal termination and the slot is freed. While a slot is busy, any other delayed cycle from that port is retried and is not recorded. Posted writes keep completing while a slot is busy.

The responses are registered. Device-select, done and retry appear in the clock cycle after the one in which the transaction was presented, and each lasts one cycle.

Top module: `tri_bridge_claim`

## Requirements
- R1: A port-0 cycle whose address falls in the port-0 window is never claimed. A port-0 cycle presented while `pri_peer_sel` is high is never claimed either.
- R2: A port-0 cycle whose address falls in the port-1 or port-2 window, with `pri_peer_sel` low, is claimed: `out_devsel[0]` is high in the next cycle.
- R3: A cycle whose address falls in no window is not claimed on any port, so that cycle ends in master abort.
- R4: A port-1 or port-2 cycle aimed at its own port's window is not claimed. One aimed at the port-0 window or at the other downstream window is claimed on that port's device-select.
- R5: A claimed cycle with command code 4'b0111 (memory write) or 4'b1111 (memory write and invalidate) gets done. Any other claimed command gets retry.
- R6: A claimed non-postable cycle that arrives at an empty slot is retried and recorded. From the next cycle, `fwd_req[p]` is high and presents the target port index (0, 1 or 2), the address, the command and the byte enables. These stay unchanged until `fwd_done[p]` arrives. `fwd_done[p]` has no effect while the slot is not waiting for the target side.
- R7: After `fwd_done[p]`, a cycle from port p whose address, command and byte enables all equal the recorded ones gets done. The slot then becomes empty, so the next delayed cycle is recorded again.
- R8: While a slot is occupied, two kinds of non-postable cycle are retried and the recorded request stays unchanged: one that differs in address, command or byte enables, and an exact repeat that arrives before `fwd_done[p]`.
- R9: An exact repeat presented in the same cycle as `fwd_done[p]` is retried. The next exact repeat gets done.
- R10: A postable cycle from port p completes with done even while slot p is occupied, and slot p is left unchanged.
- R11: `out_devsel[p]` is high exactly in the cycle after a claimed transaction, together with exactly one of `out_done[p]` and `out_retry[p]`. All three are low in every other cycle.
- R12: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 3 | Transaction present on port p (bit p) |
| in_addr | input | 3*AW | Address per port, port p at bits [p*AW +: AW] |
| in_cmd | input | 12 | 4-bit command per port, port p at bits [p*4 +: 4] |
| in_be | input | 3*BEW | Byte enables per port |
| pri_peer_sel | input | 1 | Another port-0 agent has claimed the current cycle with fast or medium decode |
| out_devsel | output | 3 | Cycle claimed on port p |
| out_done | output | 3 | Normal termination on port p |
| out_retry | output | 3 | Retry termination on port p |
| fwd_req | output | 3 | Slot p holds a request waiting for its target |
| fwd_tport | output | 6 | Target port index of slot p, at bits [p*2 +: 2] |
| fwd_addr | output | 3*AW | Recorded address of slot p |
| fwd_cmd | output | 12 | Recorded command of slot p |
| fwd_be | output | 3*BEW | Recorded byte enables of slot p |
| fwd_done | input | 3 | Target side has finished the request of slot p |

## Verification
Two functions of the block can fall on the same slot in the same cycle. The first is the target-completion notice for a waiting request. The second is either the initiator's repeat of that request or a posted write from the same port. The bench provokes both collisions in directed steps. In the random phase it raises `fwd_done` often while frequently replaying the recorded request or sending memory writes. A bench model resolves each cycle from the slot state as it stood before the clock edge. A same-cycle repeat must therefore be retried and the following repeat completed, while the posted write must complete without changing the recorded request.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int unsigned NPORT = 3;
  localparam int unsigned PIDW  = 2;
  localparam int unsigned CMDW  = 4;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_PEND  = 2'd1,
    SLOT_READY = 2'd2
  } slot_st_e;

  localparam logic [CMDW-1:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [CMDW-1:0] CMD_MEM_WRI = 4'b1111;

  function automatic logic cmd_postable(input logic [CMDW-1:0] c);
    return (c == CMD_MEM_WR) || (c == CMD_MEM_WRI);
  endfunction
endpackage

// File: rtl/xb_rst_sync.sv
module xb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/xb_win_decode.sv
module xb_win_decode #(
  parameter int unsigned    AW = 32,
  parameter logic [AW-1:0] LO = '0,
  parameter logic [AW-1:0] HI = '1
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/xb_delay_slot.sv
module xb_delay_slot
  import xb_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned BEW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [PIDW-1:0] req_tport,
  input  logic [AW-1:0]   req_addr,
  input  logic [CMDW-1:0] req_cmd,
  input  logic [BEW-1:0]  req_be,
  input  logic            tgt_done,
  output logic            grant_done,
  output logic            fwd_req,
  output logic [PIDW-1:0] fwd_tport,
  output logic [AW-1:0]   fwd_addr,
  output logic [CMDW-1:0] fwd_cmd,
  output logic [BEW-1:0]  fwd_be
);
  slot_st_e st_q, st_d;
  logic     load_en;
  logic     same_cyc;

  assign same_cyc = (req_addr == fwd_addr) && (req_cmd == fwd_cmd) && (req_be == fwd_be);

  always_comb begin
    st_d       = st_q;
    load_en    = 1'b0;
    grant_done = 1'b0;
    unique case (st_q)
      SLOT_EMPTY: if (req) begin
        load_en = 1'b1;
        st_d    = SLOT_PEND;
      end
      SLOT_PEND:  if (tgt_done) st_d = SLOT_READY;
      SLOT_READY: if (req && same_cyc) begin
        grant_done = 1'b1;
        st_d       = SLOT_EMPTY;
      end
      default:    st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SLOT_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_tport <= '0;
      fwd_addr  <= '0;
      fwd_cmd   <= '0;
      fwd_be    <= '0;
    end else if (load_en) begin
      fwd_tport <= req_tport;
      fwd_addr  <= req_addr;
      fwd_cmd   <= req_cmd;
      fwd_be    <= req_be;
    end
  end

  assign fwd_req = (st_q == SLOT_PEND);

  // R6: a waiting request is held, unchanged, until the target answers
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_req && !tgt_done) |=> (fwd_req && $stable(fwd_addr) && $stable(fwd_cmd) && $stable(fwd_be)));

  // R7: a completed repeat frees the slot
  assert_free_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_done |=> (st_q == SLOT_EMPTY));

  // R8: an occupied slot never takes a new request
  assert_no_relatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SLOT_EMPTY) |=> ($stable(fwd_addr) && $stable(fwd_cmd) && $stable(fwd_be) && $stable(fwd_tport)));
endmodule

// File: rtl/tri_bridge_claim.sv
module tri_bridge_claim
  import xb_pkg::*;
#(
  parameter int unsigned    AW      = 32,
  parameter int unsigned    BEW     = 4,
  parameter logic [AW-1:0] WIN0_LO = 32'h0000_0000,
  parameter logic [AW-1:0] WIN0_HI = 32'h3FFF_FFFF,
  parameter logic [AW-1:0] WIN1_LO = 32'h4000_0000,
  parameter logic [AW-1:0] WIN1_HI = 32'h5FFF_FFFF,
  parameter logic [AW-1:0] WIN2_LO = 32'h6000_0000,
  parameter logic [AW-1:0] WIN2_HI = 32'h7FFF_FFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      in_valid,
  input  logic [NPORT*AW-1:0]   in_addr,
  input  logic [NPORT*CMDW-1:0] in_cmd,
  input  logic [NPORT*BEW-1:0]  in_be,
  input  logic                  pri_peer_sel,
  output logic [NPORT-1:0]      out_devsel,
  output logic [NPORT-1:0]      out_done,
  output logic [NPORT-1:0]      out_retry,
  output logic [NPORT-1:0]      fwd_req,
  output logic [NPORT*PIDW-1:0] fwd_tport,
  output logic [NPORT*AW-1:0]   fwd_addr,
  output logic [NPORT*CMDW-1:0] fwd_cmd,
  output logic [NPORT*BEW-1:0]  fwd_be,
  input  logic [NPORT-1:0]      fwd_done
);
  logic rst_sn;

  xb_rst_sync u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .rst_sn(rst_sn)
  );

  logic [NPORT-1:0] claim_w, post_w, dly_w, slot_done_w;
  logic [NPORT-1:0] devsel_d, done_d, retry_d;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic IS_PRI = (p == 0);
    logic [NPORT-1:0] hit;
    logic [PIDW-1:0]  tgt;
    logic             any_hit;

    for (genvar t = 0; t < NPORT; t++) begin : g_win
      localparam logic [AW-1:0] LO = (t == 0) ? WIN0_LO : (t == 1) ? WIN1_LO : WIN2_LO;
      localparam logic [AW-1:0] HI = (t == 0) ? WIN0_HI : (t == 1) ? WIN1_HI : WIN2_HI;
      xb_win_decode #(.AW(AW), .LO(LO), .HI(HI)) u_dec (
        .addr(in_addr[p*AW +: AW]),
        .hit (hit[t])
      );
    end

    // lowest window index wins if windows overlap
    always_comb begin
      if (hit[0])      tgt = PIDW'(0);
      else if (hit[1]) tgt = PIDW'(1);
      else             tgt = PIDW'(2);
    end
    assign any_hit = |hit;

    assign claim_w[p] = in_valid[p] & any_hit & (tgt != PIDW'(p)) & ~(IS_PRI & pri_peer_sel);
    assign post_w[p]  = claim_w[p] & cmd_postable(in_cmd[p*CMDW +: CMDW]);
    assign dly_w[p]   = claim_w[p] & ~post_w[p];

    xb_delay_slot #(.AW(AW), .BEW(BEW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_sn),
      .req       (dly_w[p]),
      .req_tport (tgt),
      .req_addr  (in_addr[p*AW +: AW]),
      .req_cmd   (in_cmd[p*CMDW +: CMDW]),
      .req_be    (in_be[p*BEW +: BEW]),
      .tgt_done  (fwd_done[p]),
      .grant_done(slot_done_w[p]),
      .fwd_req   (fwd_req[p]),
      .fwd_tport (fwd_tport[p*PIDW +: PIDW]),
      .fwd_addr  (fwd_addr[p*AW +: AW]),
      .fwd_cmd   (fwd_cmd[p*CMDW +: CMDW]),
      .fwd_be    (fwd_be[p*BEW +: BEW])
    );

    // R11: device-select comes with exactly one termination
    assert_devsel_term_R11: assert property (@(posedge clk) disable iff (!rst_sn)
      out_devsel[p] |-> ($countones({out_done[p], out_retry[p]}) == 1));
    assert_no_term_alone_R11: assert property (@(posedge clk) disable iff (!rst_sn)
      !out_devsel[p] |-> (!out_done[p] && !out_retry[p]));
  end

  always_comb begin
    devsel_d = claim_w;
    done_d   = post_w | slot_done_w;
    retry_d  = dly_w & ~slot_done_w;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_devsel <= '0;
      out_done   <= '0;
      out_retry  <= '0;
    end else begin
      out_devsel <= devsel_d;
      out_done   <= done_d;
      out_retry  <= retry_d;
    end
  end

  // R1: a peer claim on port 0 always keeps the bridge silent there
  assert_peer_silent_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid[0] && pri_peer_sel) |=> !out_devsel[0]);
endmodule

// File: tb/tri_bridge_claim_tb_top.sv
`timescale 1ns/1ps
module tri_bridge_claim_tb_top;
  localparam int AW = 32;
  localparam int BEW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] v, fdone;
  logic       peer;
  logic [31:0] a[3];
  logic [3:0]  c[3];
  logic [3:0]  b[3];

  logic [2:0]  in_valid, out_devsel, out_done, out_retry, fwd_req, fwd_done;
  logic [95:0] in_addr, fwd_addr;
  logic [11:0] in_cmd, in_be, fwd_cmd, fwd_be;
  logic [5:0]  fwd_tport;

  always_comb begin
    in_valid = v;
    fwd_done = fdone;
    for (int p = 0; p < 3; p++) begin
      in_addr[p*32 +: 32] = a[p];
      in_cmd[p*4 +: 4]    = c[p];
      in_be[p*4 +: 4]     = b[p];
    end
  end

  tri_bridge_claim #(.AW(AW), .BEW(BEW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_cmd(in_cmd),
    .in_be(in_be), .pri_peer_sel(peer), .out_devsel(out_devsel), .out_done(out_done),
    .out_retry(out_retry), .fwd_req(fwd_req), .fwd_tport(fwd_tport), .fwd_addr(fwd_addr),
    .fwd_cmd(fwd_cmd), .fwd_be(fwd_be), .fwd_done(fwd_done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int          mst[3];
  logic [31:0] maddr[3];
  logic [3:0]  mcmd[3], mbe[3];
  logic [1:0]  mtp[3];

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int bdec(input logic [31:0] x);
    if (x <= 32'h3FFF_FFFF) return 0;
    if (x >= 32'h4000_0000 && x <= 32'h5FFF_FFFF) return 1;
    if (x >= 32'h6000_0000 && x <= 32'h7FFF_FFFF) return 2;
    return 3;
  endfunction

  task automatic idle();
    v = 3'b000; fdone = 3'b000; peer = 1'b0;
  endtask

  task automatic drv(input int p, input logic [31:0] ad, input logic [3:0] cm, input logic [3:0] be);
    v[p] = 1'b1; a[p] = ad; c[p] = cm; b[p] = be;
  endtask

  task automatic cyc();
    logic  ed[3], edn[3], er[3];
    string dt[3], rt[3], ft;
    for (int p = 0; p < 3; p++) begin
      int   tg;
      logic claim, post, match;
      tg = bdec(a[p]);
      if (!v[p])        dt[p] = "R11";
      else if (tg == 3) dt[p] = "R3";
      else if (p == 0)  dt[p] = (tg == 0 || peer) ? "R1" : "R2";
      else              dt[p] = "R4";
      claim = v[p] && tg != 3 && tg != p && !(p == 0 && peer);
      post  = claim && (c[p] == 4'b0111 || c[p] == 4'b1111);
      match = (a[p] == maddr[p]) && (c[p] == mcmd[p]) && (b[p] == mbe[p]);
      ed[p] = claim; edn[p] = 1'b0; er[p] = 1'b0; rt[p] = dt[p];
      if (claim && post) begin
        edn[p] = 1'b1; rt[p] = (mst[p] != 0) ? "R10" : "R5";
        if (mst[p] == 1 && fdone[p]) mst[p] = 2;
      end else if (claim) begin
        case (mst[p])
          0: begin er[p] = 1'b1; rt[p] = "R6"; mst[p] = 1;
                   maddr[p] = a[p]; mcmd[p] = c[p]; mbe[p] = b[p]; mtp[p] = 2'(tg); end
          1: begin er[p] = 1'b1; rt[p] = (match && fdone[p]) ? "R9" : "R8";
                   if (fdone[p]) mst[p] = 2; end
          default: begin
            if (match) begin edn[p] = 1'b1; rt[p] = "R7"; mst[p] = 0; end
            else begin er[p] = 1'b1; rt[p] = "R8"; end
          end
        endcase
      end else if (mst[p] == 1 && fdone[p]) mst[p] = 2;
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      check(dt[p], $sformatf("devsel[%0d]", p), 32'(out_devsel[p]), 32'(ed[p]));
      check(rt[p], $sformatf("done[%0d]", p),   32'(out_done[p]),   32'(edn[p]));
      check(rt[p], $sformatf("retry[%0d]", p),  32'(out_retry[p]),  32'(er[p]));
      ft = (rt[p] == "R8" || rt[p] == "R9" || rt[p] == "R10" || rt[p] == "R7") ? rt[p] : "R6";
      check(ft, $sformatf("fwd_req[%0d]", p), 32'(fwd_req[p]), 32'(mst[p] == 1));
      if (mst[p] == 1) begin
        check(ft, $sformatf("fwd_tport[%0d]", p), 32'(fwd_tport[p*2 +: 2]), 32'(mtp[p]));
        check(ft, $sformatf("fwd_addr[%0d]", p),  fwd_addr[p*32 +: 32],    maddr[p]);
        check(ft, $sformatf("fwd_cmd[%0d]", p),   32'(fwd_cmd[p*4 +: 4]),  32'(mcmd[p]));
        check(ft, $sformatf("fwd_be[%0d]", p),    32'(fwd_be[p*4 +: 4]),   32'(mbe[p]));
      end
    end
    idle();
  endtask

  function automatic logic [31:0] raddr();
    logic [31:0] base;
    case ($urandom_range(0, 3))
      0: base = 32'h1000_0000;
      1: base = 32'h4000_0000;
      2: base = 32'h6000_0000;
      default: base = 32'h9000_0000;
    endcase
    return base + 32'($urandom_range(0, 2) * 4);
  endfunction

  function automatic logic [3:0] rcmd();
    logic [3:0] l[9] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
    return l[$urandom_range(0, 8)];
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < 3; p++) begin
      mst[p] = 0; maddr[p] = '0; mcmd[p] = '0; mbe[p] = '0; mtp[p] = '0;
      a[p] = '0; c[p] = '0; b[p] = '0;
    end
    idle();
    // R12: reset state while asserted
    repeat (3) @(negedge clk);
    check("R12", "devsel", 32'(out_devsel), 0);
    check("R12", "done",   32'(out_done),   0);
    check("R12", "retry",  32'(out_retry),  0);
    check("R12", "fwd_req", 32'(fwd_req),   0);
    rst_n = 1'b1;
    repeat (3) cyc();

    // directed corner cases
    drv(0, 32'h1000_0000, 4'h7, 4'hF); cyc();                 // R1 local
    drv(0, 32'h4000_0000, 4'h7, 4'hF); peer = 1'b1; cyc();    // R1 peer
    drv(0, 32'h4000_0000, 4'h7, 4'hF); cyc();                 // R2 / R5 post
    drv(0, 32'h9000_0000, 4'h6, 4'hF); cyc();                 // R3
    drv(1, 32'h4000_0010, 4'h6, 4'hF);                        // R4 own bus
    drv(2, 32'h4000_0000, 4'h6, 4'hF); cyc();                 // R4 claim, R6 latch
    drv(2, 32'h4000_0000, 4'h6, 4'h3); cyc();                 // R8 mismatch
    drv(2, 32'h4000_0000, 4'h6, 4'hF); cyc();                 // R8 early repeat
    drv(2, 32'h1000_0000, 4'hF, 4'hF); cyc();                 // R10 posted passes
    drv(2, 32'h4000_0000, 4'h6, 4'hF); fdone[2] = 1'b1; cyc(); // R9 same-cycle
    drv(2, 32'h4000_0000, 4'h6, 4'hF); cyc();                 // R7 completes
    drv(2, 32'h1000_0004, 4'hA, 4'h3); cyc();                 // R6 relatch after free
    fdone[2] = 1'b1; cyc();
    drv(2, 32'h1000_0004, 4'hA, 4'h3); cyc();                 // R7

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      peer = ($urandom_range(0, 9) == 0);
      for (int p = 0; p < 3; p++) begin
        if ($urandom_range(0, 1) == 1) begin
          if (mst[p] != 0 && $urandom_range(0, 9) < 4)
            drv(p, maddr[p], mcmd[p], mbe[p]);
          else
            drv(p, raddr(), rcmd(), ($urandom_range(0, 1) == 1) ? 4'hF : 4'h3);
        end
        fdone[p] = ($urandom_range(0, 9) < 3);
      end
      cyc();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule